// File: doc/BRIEF.md
# Multi-Role Logic Macrocell

This block is one cell of a programmable logic fabric. Four product-sum bits (`sum_a` to `sum_d`) arrive from an external AND/OR plane. A static configuration word gives each of them a role: data input to the storage element, second JK input, set or clear, clock enable, or output enable. A sum bit can also feed straight through to an output. The cell holds one storage bit. That bit behaves as a D, T or JK flip-flop, and a global type-select line can change its behaviour from one cycle to the next.

Each function output picks, on its own, either the new register value or one of the sums A, B or C. A separate output enable comes from sum D or is held on. Everything runs on a single system clock. A sum-driven or globally driven "clock" is an enable that is sampled on that clock, and its active level can be inverted. The surrounding fabric can load counters as D and count as T without extra product terms.

Top module: `logic_macrocell`

## Requirements
- R1: A high `rst` at a rising edge clears the register, drives all `fn_out` bits to 0 and drives `oe_out` to 0 from that edge on.
- R2: In D behaviour (cfg[1:0] = 0 or 3), on an edge where the clock enable is active, the register takes the value of `sum_a`.
- R3: In T behaviour (cfg[1:0] = 1), on an active edge the register inverts when `sum_a` is 1 and keeps its value when `sum_a` is 0.
- R4: In JK behaviour (cfg[1:0] = 2), with J = `sum_a` and K = `sum_b`, the register acts as follows on an active edge: 1/1 inverts, 0/0 keeps, 1/0 sets, 0/1 clears. K is 1 only when cfg[6:5] = 1; otherwise K is taken as 0.
- R5: Clear wins over set and over the clock enable. Clear is active when `g_reset` is 1, or when cfg[8:7] = 1 and `sum_c` is 1.
- R6: Set is active when `g_preset` is 1, or when cfg[6:5] = 2 and `sum_b` is 1. When clear is not active, set forces the register to 1 regardless of the clock enable.
- R7: The clock source is selected by cfg[10:9]: 1 selects `sum_c`, 2 selects `sum_d`, and 0 or 3 selects `g_clk_en`. cfg[11] = 1 makes the enable active when the source is 0. When the enable is not active, and there is no set or clear, the register keeps its value.
- R8: When cfg[4] = 1 and `g_rtype` = 1, the behaviour given by cfg[3:2] replaces the one in cfg[1:0]. When cfg[4] = 0, `g_rtype` has no effect.
- R9: Each output i takes its source from cfg[14+2i:13+2i]. Code 0 is the register value after the edge, 1 is `sum_a`, 2 is `sum_b` and 3 is `sum_c`. Every output is registered and is valid one edge after its inputs.
- R10: `oe_out` is registered. It follows `sum_d` when cfg[12] = 1, and it is 1 when cfg[12] = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg | input | 13+2*N_OUT | Static configuration word |
| sum_a | input | 1 | Sum term A: data, J or pass-through |
| sum_b | input | 1 | Sum term B: K, set or pass-through |
| sum_c | input | 1 | Sum term C: clock enable, clear or pass-through |
| sum_d | input | 1 | Sum term D: clock enable or output enable |
| g_clk_en | input | 1 | Global clock enable |
| g_preset | input | 1 | Global set |
| g_reset | input | 1 | Global clear |
| g_rtype | input | 1 | Global dynamic register-type select |
| fn_out | output | N_OUT | Function outputs |
| oe_out | output | 1 | Output enable for the attached pad |

## Verification
Every result of this cell (the new register value seen through an output, a pass-through sum and the output enable) is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check sees the value from that edge alone. The register value carries from one vector to the next. The expected values in the table therefore chain: the hold, toggle and dynamic-type cases start from a known prior value that makes a wrong behaviour visible.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

  localparam int CFG_BASE_W = 13;
  localparam int SEL_W      = 2;

  localparam int F_BASE   = 0;
  localparam int F_DYN    = 2;
  localparam int F_FOLLOW = 4;
  localparam int F_BROLE  = 5;
  localparam int F_CROLE  = 7;
  localparam int F_CSRC   = 9;
  localparam int F_POL    = 11;
  localparam int F_OED    = 12;
  localparam int F_SEL    = 13;

  typedef enum logic [1:0] {
    KIND_D  = 2'd0,
    KIND_T  = 2'd1,
    KIND_JK = 2'd2,
    KIND_D2 = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    BR_COMB  = 2'd0,
    BR_K     = 2'd1,
    BR_SET   = 2'd2,
    BR_COMB2 = 2'd3
  } b_role_e;

  typedef enum logic [1:0] {
    CR_COMB  = 2'd0,
    CR_CLR   = 2'd1,
    CR_COMB2 = 2'd2,
    CR_COMB3 = 2'd3
  } c_role_e;

  typedef enum logic [1:0] {
    CS_GLOBAL  = 2'd0,
    CS_SUM_C   = 2'd1,
    CS_SUM_D   = 2'd2,
    CS_GLOBAL2 = 2'd3
  } clk_src_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      tick;
    logic      set;
    logic      clr;
    logic      d_in;
    logic      k_in;
  } cell_ctrl_t;

endpackage

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import macrocell_pkg::*;
#(
  parameter int CFG_W = 17
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_a,
  input  logic             sum_b,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic             g_clk_en,
  input  logic             g_preset,
  input  logic             g_reset,
  input  logic             g_rtype,
  output cell_ctrl_t       ctrl
);

  reg_kind_e base_kind;
  reg_kind_e dyn_kind;
  b_role_e   b_role;
  c_role_e   c_role;
  clk_src_e  clk_src;
  logic      src_level;

  assign base_kind = reg_kind_e'(cfg[F_BASE +: 2]);
  assign dyn_kind  = reg_kind_e'(cfg[F_DYN +: 2]);
  assign b_role    = b_role_e'(cfg[F_BROLE +: 2]);
  assign c_role    = c_role_e'(cfg[F_CROLE +: 2]);
  assign clk_src   = clk_src_e'(cfg[F_CSRC +: 2]);

  always_comb begin
    unique case (clk_src)
      CS_SUM_C: src_level = sum_c;
      CS_SUM_D: src_level = sum_d;
      default:  src_level = g_clk_en;
    endcase
  end

  always_comb begin
    ctrl.kind = (cfg[F_FOLLOW] && g_rtype) ? dyn_kind : base_kind;
    ctrl.tick = src_level ^ cfg[F_POL];
    ctrl.clr  = g_reset | ((c_role == CR_CLR) & sum_c);
    ctrl.set  = g_preset | ((b_role == BR_SET) & sum_b);
    ctrl.d_in = sum_a;
    ctrl.k_in = (b_role == BR_K) & sum_b;
  end

endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import macrocell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cell_ctrl_t ctrl,
  output logic       q,
  output logic       q_next
);

  always_comb begin
    q_next = q;
    if (ctrl.clr) begin
      q_next = 1'b0;
    end else if (ctrl.set) begin
      q_next = 1'b1;
    end else if (ctrl.tick) begin
      unique case (ctrl.kind)
        KIND_T:  q_next = q ^ ctrl.d_in;
        KIND_JK: begin
          unique case ({ctrl.d_in, ctrl.k_in})
            2'b11:   q_next = ~q;
            2'b10:   q_next = 1'b1;
            2'b01:   q_next = 1'b0;
            default: q_next = q;
          endcase
        end
        default: q_next = ctrl.d_in;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  // R5: clear dominates everything
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ctrl.clr |=> (q == 1'b0));

  // R6: set without clear forces one
  a_r6_set_forces: assert property (@(posedge clk) disable iff (rst)
    (ctrl.set && !ctrl.clr) |=> q);

  // R7: no enable, no set, no clear means hold
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.tick && !ctrl.set && !ctrl.clr) |=> $stable(q));

  // R2: D behaviour loads data
  a_r2_d_loads: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tick && !ctrl.set && !ctrl.clr &&
     (ctrl.kind == KIND_D || ctrl.kind == KIND_D2)) |=> (q == $past(ctrl.d_in)));

  // R3: T behaviour inverts on one
  a_r3_t_inverts: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tick && !ctrl.set && !ctrl.clr && ctrl.kind == KIND_T && ctrl.d_in)
    |=> (q != $past(q)));

  // R4: JK set case
  a_r4_jk_sets: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tick && !ctrl.set && !ctrl.clr && ctrl.kind == KIND_JK &&
     ctrl.d_in && !ctrl.k_in) |=> q);

endmodule

// File: rtl/mc_out_mux.sv
module mc_out_mux
  import macrocell_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_OUT*SEL_W-1:0] sel_bus,
  input  logic                   oe_by_d,
  input  logic                   q_next,
  input  logic                   sum_a,
  input  logic                   sum_b,
  input  logic                   sum_c,
  input  logic                   sum_d,
  output logic [N_OUT-1:0]       fn_out,
  output logic                   oe_out
);

  logic [N_OUT-1:0] pick;

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    logic [SEL_W-1:0] sel;
    assign sel = sel_bus[gi*SEL_W +: SEL_W];

    always_comb begin
      unique case (sel)
        2'd1:    pick[gi] = sum_a;
        2'd2:    pick[gi] = sum_b;
        2'd3:    pick[gi] = sum_c;
        default: pick[gi] = q_next;
      endcase
    end

    // R9: pass-through of sum A is one edge late
    a_r9_pass_a: assert property (@(posedge clk) disable iff (rst)
      (sel == 2'd1) |=> (fn_out[gi] == $past(sum_a)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_out <= '0;
      oe_out <= 1'b0;
    end else begin
      fn_out <= pick;
      oe_out <= oe_by_d ? sum_d : 1'b1;
    end
  end

  // R10: enable held on when sum D is not its source
  a_r10_oe_on: assert property (@(posedge clk) disable iff (rst)
    !oe_by_d |=> oe_out);

endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
  import macrocell_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [CFG_BASE_W+SEL_W*N_OUT-1:0]  cfg,
  input  logic                               sum_a,
  input  logic                               sum_b,
  input  logic                               sum_c,
  input  logic                               sum_d,
  input  logic                               g_clk_en,
  input  logic                               g_preset,
  input  logic                               g_reset,
  input  logic                               g_rtype,
  output logic [N_OUT-1:0]                   fn_out,
  output logic                               oe_out
);

  localparam int CFG_W = CFG_BASE_W + SEL_W * N_OUT;

  cell_ctrl_t ctrl;
  logic       q;
  logic       q_next;

  mc_ctrl_decode #(.CFG_W(CFG_W)) u_decode (
    .cfg      (cfg),
    .sum_a    (sum_a),
    .sum_b    (sum_b),
    .sum_c    (sum_c),
    .sum_d    (sum_d),
    .g_clk_en (g_clk_en),
    .g_preset (g_preset),
    .g_reset  (g_reset),
    .g_rtype  (g_rtype),
    .ctrl     (ctrl)
  );

  mc_state_reg u_state (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .q      (q),
    .q_next (q_next)
  );

  mc_out_mux #(.N_OUT(N_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .sel_bus (cfg[F_SEL +: SEL_W*N_OUT]),
    .oe_by_d (cfg[F_OED]),
    .q_next  (q_next),
    .sum_a   (sum_a),
    .sum_b   (sum_b),
    .sum_c   (sum_c),
    .sum_d   (sum_d),
    .fn_out  (fn_out),
    .oe_out  (oe_out)
  );

  // R1: reset drives every output low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (fn_out == '0 && !oe_out));

  // R9: output fed by the register tracks it after the edge
  a_r9_reg_view: assert property (@(posedge clk) disable iff (rst)
    (cfg[F_SEL +: SEL_W] == 2'd0) |=> (fn_out[0] == q));

endmodule

// File: tb/logic_macrocell_tb_top.sv
`timescale 1ns/1ps
module logic_macrocell_tb_top;

  localparam int N_OUT = 2;
  localparam int CW    = 13 + 2 * N_OUT;
  localparam int NV    = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg = '0;
  logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
  logic g_clk_en = 0, g_preset = 0, g_reset = 0, g_rtype = 0;
  logic [N_OUT-1:0] fn_out;
  logic oe_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  logic_macrocell #(.N_OUT(N_OUT)) dut_i (
    .clk(clk), .rst(rst), .cfg(cfg),
    .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
    .g_clk_en(g_clk_en), .g_preset(g_preset), .g_reset(g_reset), .g_rtype(g_rtype),
    .fn_out(fn_out), .oe_out(oe_out)
  );

  typedef struct packed {
    logic [1:0] base, dyn;
    logic       fol;
    logic [1:0] br, cr, cs;
    logic       pol, oed;
    logic [1:0] s1;
    logic       a, b, c, d, gce, gp, gr, grt;
    logic       eq, eo1, eoe;
    logic [3:0] req;
  } vec_t;

  // base dyn fol br cr cs pol oed s1 | a b c d gce gp gr grt | eq eo1 eoe | req
  localparam vec_t VEC [NV] = '{
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd1, 1,0,0,0,1,0,0,0, 1,1,1, 4'd2},  // R2 load 1
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd2, 0,1,0,0,1,0,0,0, 0,1,1, 4'd9},  // R9 view B
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd3, 1,0,1,0,0,0,0,0, 0,1,1, 4'd7},  // R7 no enable
    '{2'd1,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,0, 1,1,1, 4'd3},  // R3 toggle
    '{2'd1,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,0, 0,0,1, 4'd3},  // R3 toggle
    '{2'd1,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b1,2'd1, 0,0,0,1,1,0,0,0, 0,0,1, 4'd10}, // R10 oe=D=1
    '{2'd1,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b1,2'd0, 1,0,0,0,1,0,0,0, 1,1,0, 4'd10}, // R10 oe=D=0
    '{2'd2,2'd0,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0,2'd2, 0,0,0,0,1,0,0,0, 1,0,1, 4'd4},  // R4 hold
    '{2'd2,2'd0,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0,2'd2, 0,1,0,0,1,0,0,0, 0,1,1, 4'd4},  // R4 clear
    '{2'd2,2'd0,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,0, 1,1,1, 4'd4},  // R4 set
    '{2'd2,2'd0,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0,2'd0, 1,1,0,0,1,0,0,0, 0,0,1, 4'd4},  // R4 toggle
    '{2'd2,2'd0,1'b0,2'd1,2'd0,2'd0,1'b0,1'b0,2'd0, 1,1,0,0,1,0,0,0, 1,1,1, 4'd4},  // R4 toggle
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 0,0,0,0,1,0,0,0, 0,0,1, 4'd2},  // R2 load 0
    '{2'd0,2'd0,1'b0,2'd2,2'd0,2'd0,1'b0,1'b0,2'd2, 0,1,0,0,1,0,0,0, 1,1,1, 4'd6},  // R6 set via B
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,1,1,0, 0,0,1, 4'd5},  // R5 clear beats set
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 0,0,0,0,0,1,0,0, 1,1,1, 4'd6},  // R6 set, no enable
    '{2'd0,2'd0,1'b0,2'd2,2'd1,2'd0,1'b0,1'b0,2'd3, 1,1,1,0,1,0,0,0, 0,1,1, 4'd5},  // R5 clear via C
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd1,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,0, 0,0,1, 4'd7},  // R7 C low
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd1,1'b0,1'b0,2'd0, 1,0,1,0,0,0,0,0, 1,1,1, 4'd7},  // R7 C high
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd2,1'b1,1'b0,2'd0, 0,0,0,1,1,0,0,0, 1,1,1, 4'd7},  // R7 D high inverted
    '{2'd0,2'd0,1'b0,2'd0,2'd0,2'd2,1'b1,1'b0,2'd0, 0,0,0,0,1,0,0,0, 0,0,1, 4'd7},  // R7 D low inverted
    '{2'd0,2'd1,1'b1,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,1, 1,1,1, 4'd8},  // R8 T selected
    '{2'd0,2'd1,1'b1,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 0,0,0,0,1,0,0,0, 0,0,1, 4'd8},  // R8 back to D
    '{2'd0,2'd1,1'b1,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,1, 1,1,1, 4'd8},  // R8 T selected
    '{2'd0,2'd2,1'b1,2'd1,2'd0,2'd0,1'b0,1'b0,2'd0, 1,1,0,0,1,0,0,1, 0,0,1, 4'd8},  // R8 JK selected
    '{2'd0,2'd1,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,1, 1,1,1, 4'd8},  // R8 follow off
    '{2'd0,2'd1,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd0, 1,0,0,0,1,0,0,1, 1,1,1, 4'd8},  // R8 ignored type
    '{2'd2,2'd0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,2'd2, 1,1,0,0,1,0,0,0, 1,1,1, 4'd4}   // R4 K unused
  };

  function automatic logic [CW-1:0] mk_cfg(input vec_t v);
    logic [CW-1:0] r;
    r = '0;
    r[1:0]   = v.base;
    r[3:2]   = v.dyn;
    r[4]     = v.fol;
    r[6:5]   = v.br;
    r[8:7]   = v.cr;
    r[10:9]  = v.cs;
    r[11]    = v.pol;
    r[12]    = v.oed;
    r[14:13] = 2'd0;
    r[16:15] = v.s1;
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset fn_out[0]", fn_out[0], 1'b0);
    check("R1 reset fn_out[1]", fn_out[1], 1'b0);
    check("R1 reset oe_out", oe_out, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v        = VEC[i];
      cfg      = mk_cfg(v);
      sum_a    = v.a;   sum_b   = v.b;   sum_c   = v.c;   sum_d    = v.d;
      g_clk_en = v.gce; g_preset = v.gp; g_reset = v.gr;  g_rtype  = v.grt;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec %0d register", v.req, i), fn_out[0], v.eq);
      check($sformatf("R%0d vec %0d fn_out[1]", v.req, i), fn_out[1], v.eo1);
      check($sformatf("R%0d vec %0d oe_out", v.req, i), oe_out, v.eoe);
    end

    // R1: reset in mid-run with register at 1 and enables active
    cfg = '0; sum_a = 1; g_clk_en = 1; g_preset = 0; g_reset = 0; g_rtype = 0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid reset fn_out[0]", fn_out[0], 1'b0);
    check("R1 mid reset oe_out", oe_out, 1'b0);
    rst = 1'b0; g_clk_en = 0;
    @(posedge clk);
    @(negedge clk);
    // R7: register stays cleared with no enable after reset
    check("R7 hold after reset", fn_out[0], 1'b0);
    check("R10 oe back on", oe_out, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule